// File: doc/BRIEF.md
# Disk Controller Command and Status Port

This block is the register front end of a disk controller that serves several drives. Software sends it byte or halfword data writes, which load a disk address: a sector byte and a 16-bit head/cylinder word. It also sends command bytes. The block keeps the controller status byte and decides whether a transfer command may start. When a command is accepted, the block emits a one-cycle start strobe to a separate transfer engine. The strobe carries the 6-bit function code and the number of the drive last addressed.

While a transfer is in flight, the block holds back drive interrupt requests. It releases them when the transfer engine reports completion. A completion also makes the controller idle again, folds the reported error flags into status, and raises the controller interrupt if software has armed it. The status byte reports an examine bit, derived from the four most severe error flags.

Top module: `dskctl_port`

## Requirements
- R1: After reset the status byte reads 0x0A (idle bit 1 and busy bit 3). Reset also clears the sector, the head/cylinder word, the address pointer, the selected unit, the controller arm, the controller interrupt, and both the pending and held drive interrupt requests.
- R2: A byte data write is steered by a pointer that counts 0, 1, 2 and then wraps to 0. Pointer 0 loads the sector. Pointer 1 loads bits 15:8 of the head/cylinder word. Pointer 2 loads bits 7:0 of that word.
- R3: A halfword data write acts as two byte writes in one cycle: bits 15:8 go in first, then bits 7:0.
- R4: Every command write returns the address pointer to 0, and any data write in the same cycle is dropped. Command bits 7:6 set the controller arm: 01 arms it, 10 disarms it, and 00 or 11 leave it unchanged.
- R5: A command whose bit 3 is set resets the whole block exactly as in R1. Nothing else in that command takes effect.
- R6: A command is ignored in any of these cases: its code (bits 5:0) is 0x00, its code is 0x12, the idle bit is clear, or the busy input of the selected unit is high.
- R7: An accepted command sets status to exactly 0x08 (busy only) and sets the first-transfer flag. In the next cycle it raises the start strobe for one cycle, carrying the code and the selected unit.
- R8: Status bit 2 (examine) reads 1 exactly when any of bits 7:4 is set. Those bits are write protect, address compare fail, defective track and cylinder overflow.
- R9: A drive address cycle changes the selected unit only while the idle bit is set.
- R10: On acceptance, the pending drive interrupt requests and any arriving in that cycle move into a held register, and the pending set is cleared. While the idle bit is clear, new drive requests go into the held register.
- R11: A completion is honoured only while the idle bit is clear. It sets the idle bit, clears the busy bit and the first-transfer flag, and ORs the flags masked by 0xF1 into status. It moves the held drive requests back to pending and empties the held register. It sets the controller interrupt if the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_byte_en | input | 1 | Byte data write, using wr_data[7:0] |
| wr_half_en | input | 1 | Halfword data write, using wr_data[15:0] |
| wr_data | input | 16 | Data write value |
| cmd_en | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte: arm field [7:6], code [5:0] |
| unit_sel_en | input | 1 | Drive address cycle |
| unit_sel | input | 2 | Drive number for the address cycle |
| unit_busy | input | 4 | Per-drive busy indication |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| xfer_flags | input | 8 | Error flags reported with completion |
| drv_irq_set | input | 4 | New drive interrupt requests |
| drv_irq_clr | input | 4 | Acknowledge of pending drive requests |
| ctl_irq_ack | input | 1 | Clears the controller interrupt |
| status | output | 8 | Controller status byte, including the examine bit |
| sector | output | 8 | Sector register |
| head_cyl | output | 16 | Head/cylinder register |
| start | output | 1 | One-cycle transfer start strobe |
| start_func | output | 6 | Function code of the last accepted command |
| start_unit | output | 2 | Unit of the last accepted command |
| first_xfer | output | 1 | First-transfer flag |
| ctl_irq | output | 1 | Controller interrupt request |
| drv_irq | output | 4 | Pending drive interrupt requests |

## Verification
The in-line assertions check, on every cycle, the following properties:
- the address pointer never reaches its unused value;
- a command always zeroes the pointer;
- a start strobe coincides with a busy-only status and lasts a single cycle;
- no start follows a command issued while the idle bit was clear;
- the held and pending drive request sets are emptied at completion and acceptance.

Only the bench's scenarios can show the cases that need a reference sequence:
- the exact bytes landing in the sector and head/cylinder registers;
- halfword ordering;
- the ignore cases for codes 0x00 and 0x12 and for a busy unit;
- the arm encoding;
- the error flags merged at completion;
- the interaction of unit selection with busy periods.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 6;

  // status bit positions
  localparam int B_WPROT = 7;
  localparam int B_ACMP  = 6;
  localparam int B_DEFT  = 5;
  localparam int B_CYLO  = 4;
  localparam int B_BUSY  = 3;
  localparam int B_EXAM  = 2;
  localparam int B_IDLE  = 1;
  localparam int B_XERR  = 0;

  localparam logic [7:0] STA_AFTER_RST = 8'h0A;
  localparam logic [7:0] STA_RUNNING   = 8'h08;
  localparam logic [7:0] ERR_KEEP_MASK = 8'hF1;

  localparam int             CLR_BIT   = 3;
  localparam logic [CODE_W-1:0] CODE_NOP  = 6'h00;
  localparam logic [CODE_W-1:0] CODE_SKIP = 6'h12;

  typedef enum logic [1:0] {
    ARM_HOLD  = 2'b00,
    ARM_SET   = 2'b01,
    ARM_DROP  = 2'b10,
    ARM_HOLD2 = 2'b11
  } arm_op_e;

  typedef struct packed {
    logic [1:0]        ptr;
    logic [BYTE_W-1:0] sec;
    logic [2*BYTE_W-1:0] hc;
  } addr_state_t;
endpackage

// File: rtl/dcp_addr_load.sv
module dcp_addr_load
  import dcp_pkg::*;
(
  input  logic                clk,
  input  logic                wipe,
  input  logic                ptr_zero,
  input  logic                byte_en,
  input  logic                half_en,
  input  logic [2*BYTE_W-1:0] data,
  output logic [BYTE_W-1:0]   sector,
  output logic [2*BYTE_W-1:0] head_cyl
);
  localparam int HC_W = 2 * BYTE_W;

  addr_state_t cur_q, step1, step2, nxt;

  function automatic addr_state_t put_byte(addr_state_t s, logic [BYTE_W-1:0] b);
    addr_state_t r;
    r = s;
    case (s.ptr)
      2'd0:    begin r.sec = b;                   r.ptr = 2'd1; end
      2'd1:    begin r.hc[HC_W-1:BYTE_W] = b;     r.ptr = 2'd2; end
      default: begin r.hc[BYTE_W-1:0] = b;        r.ptr = 2'd0; end
    endcase
    return r;
  endfunction

  always_comb begin
    step1 = put_byte(cur_q, half_en ? data[HC_W-1:BYTE_W] : data[BYTE_W-1:0]);
    step2 = put_byte(step1, data[BYTE_W-1:0]);
    nxt   = cur_q;
    if (ptr_zero)     nxt.ptr = 2'd0;
    else if (half_en) nxt = step2;
    else if (byte_en) nxt = step1;
  end

  always_ff @(posedge clk) begin
    if (wipe) cur_q <= '0;
    else      cur_q <= nxt;
  end

  assign sector   = cur_q.sec;
  assign head_cyl = cur_q.hc;

  a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (wipe)
    cur_q.ptr != 2'd3);
  a_r4_cmd_zeroes_ptr: assert property (@(posedge clk) disable iff (wipe)
    ptr_zero |=> cur_q.ptr == 2'd0);
endmodule

// File: rtl/dcp_irq_hold.sv
module dcp_irq_hold #(
  parameter int NUNITS = 4
) (
  input  logic              clk,
  input  logic              wipe,
  input  logic              idle,
  input  logic              accept,
  input  logic              done_ok,
  input  logic [NUNITS-1:0] req_set,
  input  logic [NUNITS-1:0] req_clr,
  output logic [NUNITS-1:0] pending
);
  logic [NUNITS-1:0] pend_q, held_q, kept;

  assign kept = pend_q & ~req_clr;

  always_ff @(posedge clk) begin
    if (wipe) begin
      pend_q <= '0;
      held_q <= '0;
    end else if (accept) begin
      held_q <= kept | req_set;
      pend_q <= '0;
    end else if (done_ok) begin
      pend_q <= kept | held_q | req_set;
      held_q <= '0;
    end else if (!idle) begin
      held_q <= held_q | req_set;
      pend_q <= kept;
    end else begin
      pend_q <= kept | req_set;
    end
  end

  assign pending = pend_q;

  a_r11_held_empty_after_done: assert property (@(posedge clk) disable iff (wipe)
    done_ok |=> held_q == '0);
  a_r10_pending_empty_after_accept: assert property (@(posedge clk) disable iff (wipe)
    accept |=> pend_q == '0);
endmodule

// File: rtl/dskctl_port.sv
module dskctl_port
  import dcp_pkg::*;
#(
  parameter int NUNITS = 4,
  localparam int UW = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_byte_en,
  input  logic                wr_half_en,
  input  logic [15:0]         wr_data,
  input  logic                cmd_en,
  input  logic [7:0]          cmd_data,
  input  logic                unit_sel_en,
  input  logic [UW-1:0]       unit_sel,
  input  logic [NUNITS-1:0]   unit_busy,
  input  logic                xfer_done,
  input  logic [7:0]          xfer_flags,
  input  logic [NUNITS-1:0]   drv_irq_set,
  input  logic [NUNITS-1:0]   drv_irq_clr,
  input  logic                ctl_irq_ack,
  output logic [7:0]          status,
  output logic [7:0]          sector,
  output logic [15:0]         head_cyl,
  output logic                start,
  output logic [CODE_W-1:0]   start_func,
  output logic [UW-1:0]       start_unit,
  output logic                first_xfer,
  output logic                ctl_irq,
  output logic [NUNITS-1:0]   drv_irq
);
  logic [7:0]        sta_q;
  logic [UW-1:0]     unit_q;
  logic              arm_q, start_q, first_q, cirq_q;
  logic [CODE_W-1:0] func_q;
  logic [UW-1:0]     sunit_q;

  logic [CODE_W-1:0] code;
  logic              wipe, idle, accept, done_ok;
  arm_op_e           arm_op;

  assign code    = cmd_data[CODE_W-1:0];
  assign arm_op  = arm_op_e'(cmd_data[7:6]);
  assign wipe    = rst | (cmd_en & cmd_data[CLR_BIT]);
  assign idle    = sta_q[B_IDLE];
  assign accept  = cmd_en & ~cmd_data[CLR_BIT] & (code != CODE_NOP) &
                   (code != CODE_SKIP) & idle & ~unit_busy[unit_q];
  assign done_ok = xfer_done & ~idle;

  always_ff @(posedge clk) begin
    if (wipe) begin
      sta_q   <= STA_AFTER_RST;
      unit_q  <= '0;
      arm_q   <= 1'b0;
      start_q <= 1'b0;
      first_q <= 1'b0;
      cirq_q  <= 1'b0;
      func_q  <= '0;
      sunit_q <= '0;
    end else begin
      start_q <= accept;
      if (cmd_en) begin
        case (arm_op)
          ARM_SET:  arm_q <= 1'b1;
          ARM_DROP: arm_q <= 1'b0;
          default:  arm_q <= arm_q;
        endcase
      end
      if (accept) begin
        sta_q   <= STA_RUNNING;
        first_q <= 1'b1;
        func_q  <= code;
        sunit_q <= unit_q;
      end
      if (unit_sel_en && idle) unit_q <= unit_sel;
      if (done_ok) begin
        sta_q <= (sta_q | (8'h1 << B_IDLE) | (xfer_flags & ERR_KEEP_MASK))
                 & ~(8'h1 << B_BUSY);
        first_q <= 1'b0;
      end
      if (done_ok && arm_q) cirq_q <= 1'b1;
      else if (ctl_irq_ack)  cirq_q <= 1'b0;
    end
  end

  dcp_addr_load u_addr (
    .clk      (clk),
    .wipe     (wipe),
    .ptr_zero (cmd_en),
    .byte_en  (wr_byte_en),
    .half_en  (wr_half_en),
    .data     (wr_data),
    .sector   (sector),
    .head_cyl (head_cyl)
  );

  dcp_irq_hold #(.NUNITS(NUNITS)) u_irq (
    .clk     (clk),
    .wipe    (wipe),
    .idle    (idle),
    .accept  (accept),
    .done_ok (done_ok),
    .req_set (drv_irq_set),
    .req_clr (drv_irq_clr),
    .pending (drv_irq)
  );

  always_comb begin
    status         = sta_q;
    status[B_EXAM] = |sta_q[B_WPROT:B_CYLO];
  end

  assign start      = start_q;
  assign start_func = func_q;
  assign start_unit = sunit_q;
  assign first_xfer = first_q;
  assign ctl_irq    = cirq_q;

  a_r1_reset_status: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sta_q == STA_AFTER_RST);
  a_r7_start_with_busy: assert property (@(posedge clk) disable iff (rst)
    start_q |-> sta_q == STA_RUNNING);
  a_r7_start_single: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  a_r6_no_start_unless_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && !idle && !cmd_data[CLR_BIT]) |=> !start_q);
endmodule

// File: tb/tb_dskctl_port.sv
module tb_dskctl_port;
  localparam int N = 4;

  logic clk = 0;
  logic rst;
  logic wr_byte_en, wr_half_en, cmd_en, unit_sel_en, xfer_done, ctl_irq_ack;
  logic [15:0] wr_data;
  logic [7:0] cmd_data, xfer_flags;
  logic [1:0] unit_sel;
  logic [N-1:0] unit_busy, drv_irq_set, drv_irq_clr;
  logic [7:0] status, sector;
  logic [15:0] head_cyl;
  logic start, first_xfer, ctl_irq;
  logic [5:0] start_func;
  logic [1:0] start_unit;
  logic [N-1:0] drv_irq;

  always #2.5 clk = ~clk;

  dskctl_port #(.NUNITS(N)) dut (
    .clk(clk), .rst(rst), .wr_byte_en(wr_byte_en), .wr_half_en(wr_half_en),
    .wr_data(wr_data), .cmd_en(cmd_en), .cmd_data(cmd_data),
    .unit_sel_en(unit_sel_en), .unit_sel(unit_sel), .unit_busy(unit_busy),
    .xfer_done(xfer_done), .xfer_flags(xfer_flags), .drv_irq_set(drv_irq_set),
    .drv_irq_clr(drv_irq_clr), .ctl_irq_ack(ctl_irq_ack), .status(status),
    .sector(sector), .head_cyl(head_cyl), .start(start), .start_func(start_func),
    .start_unit(start_unit), .first_xfer(first_xfer), .ctl_irq(ctl_irq),
    .drv_irq(drv_irq)
  );

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [7:0] m_sta, m_sec;
  logic [15:0] m_hc;
  logic [1:0] m_ptr, m_unit, m_sunit;
  logic m_arm, m_start, m_first, m_cirq;
  logic [5:0] m_func;
  logic [N-1:0] m_pend, m_held;

  function automatic logic [7:0] exp_status(logic [7:0] s);
    return s | ((s[7:4] != 0) ? 8'h04 : 8'h00);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_sta = 8'h0A; m_sec = 0; m_hc = 0; m_ptr = 0; m_unit = 0; m_sunit = 0;
    m_arm = 0; m_start = 0; m_first = 0; m_cirq = 0; m_func = 0;
    m_pend = 0; m_held = 0;
  endtask

  task automatic put_b(logic [7:0] b);
    case (m_ptr)
      2'd0: begin m_sec = b; m_ptr = 1; end
      2'd1: begin m_hc[15:8] = b; m_ptr = 2; end
      default: begin m_hc[7:0] = b; m_ptr = 0; end
    endcase
  endtask

  task automatic model_step();
    logic acc, dn, idl;
    logic [N-1:0] kept;
    logic [5:0] code;
    if (rst || (cmd_en && cmd_data[3])) begin
      model_clear();
      return;
    end
    idl  = m_sta[1];
    code = cmd_data[5:0];
    acc  = cmd_en && code != 6'h00 && code != 6'h12 && idl && !unit_busy[m_unit];
    dn   = xfer_done && !idl;
    kept = m_pend & ~drv_irq_clr;
    if (acc) begin m_held = kept | drv_irq_set; m_pend = 0; end
    else if (dn) begin m_pend = kept | m_held | drv_irq_set; m_held = 0; end
    else if (!idl) begin m_held = m_held | drv_irq_set; m_pend = kept; end
    else m_pend = kept | drv_irq_set;
    m_start = acc;
    if (dn && m_arm) m_cirq = 1;
    else if (ctl_irq_ack) m_cirq = 0;
    if (cmd_en) begin
      m_ptr = 0;
      if (cmd_data[7:6] == 2'b01) m_arm = 1;
      else if (cmd_data[7:6] == 2'b10) m_arm = 0;
    end else if (wr_half_en) begin
      put_b(wr_data[15:8]); put_b(wr_data[7:0]);
    end else if (wr_byte_en) put_b(wr_data[7:0]);
    if (acc) begin m_sta = 8'h08; m_first = 1; m_func = code; m_sunit = m_unit; end
    if (unit_sel_en && idl) m_unit = unit_sel;
    if (dn) begin m_sta = (m_sta | 8'h02 | (xfer_flags & 8'hF1)) & ~8'h08; m_first = 0; end
  endtask

  task automatic idle_inputs();
    rst = 0; wr_byte_en = 0; wr_half_en = 0; wr_data = 0; cmd_en = 0; cmd_data = 0;
    unit_sel_en = 0; unit_sel = 0; xfer_done = 0; xfer_flags = 0;
    drv_irq_set = 0; drv_irq_clr = 0; ctl_irq_ack = 0;
  endtask

  task automatic compare_all(string tag);
    chk("R8", {tag, " status"}, status, exp_status(m_sta));
    chk("R2", {tag, " sector"}, sector, m_sec);
    chk("R3", {tag, " head_cyl"}, head_cyl, m_hc);
    chk("R7", {tag, " start"}, {start, start_func, start_unit}, {m_start, m_func, m_sunit});
    chk("R7", {tag, " first"}, first_xfer, m_first);
    chk("R11", {tag, " ctl_irq"}, ctl_irq, m_cirq);
    chk("R10", {tag, " drv_irq"}, drv_irq, m_pend);
  endtask

  // apply inputs set by caller for one clock, then compare at the falling edge
  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
    idle_inputs();
  endtask

  task automatic cmd(logic [7:0] c, string tag);
    cmd_en = 1; cmd_data = c; cycle(tag);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5C_0A7E));
    idle_inputs();
    unit_busy = 0;
    model_clear();
    rst = 1;
    @(negedge clk);
    cycle("R1 reset");
    chk("R1", "status after reset", status, 8'h0A);
    chk("R1", "sector after reset", sector, 8'h00);

    // R2 byte sequence with wrap
    wr_byte_en = 1; wr_data = 16'h0011; cycle("R2 b0");
    wr_byte_en = 1; wr_data = 16'h0022; cycle("R2 b1");
    wr_byte_en = 1; wr_data = 16'h0033; cycle("R2 b2");
    chk("R2", "head_cyl after three bytes", head_cyl, 16'h2233);
    wr_byte_en = 1; wr_data = 16'h0044; cycle("R2 wrap");
    chk("R2", "sector after wrap", sector, 8'h44);

    // R4 command zeroes pointer, R3 halfword ordering
    cmd(8'h00, "R4 nop");
    wr_half_en = 1; wr_data = 16'hA5C3; cycle("R3 half0");
    chk("R3", "sector from high byte", sector, 8'hA5);
    chk("R3", "head_cyl high from low byte", head_cyl[15:8], 8'hC3);
    wr_half_en = 1; wr_data = 16'h7E19; cycle("R3 half1");
    chk("R3", "head_cyl after second half", head_cyl, 16'hC37E);
    chk("R3", "sector after wrap in half", sector, 8'h19);

    // R6 ignores: code 0x12, busy unit
    cmd(8'h52, "R6 skip code");
    chk("R6", "no start on 0x12", start, 1'b0);
    unit_sel_en = 1; unit_sel = 2; cycle("R9 select idle");
    unit_busy = 4'b0100;
    cmd(8'h01, "R6 unit busy");
    chk("R6", "no start when unit busy", start, 1'b0);
    unit_busy = 0;

    // R10 pending then accept (armed)
    drv_irq_set = 4'b0011; cycle("R10 set");
    chk("R10", "pending before accept", drv_irq, 4'b0011);
    cmd(8'h41, "R7 accept");
    chk("R7", "status busy only", status, 8'h08);
    chk("R7", "start strobe", {start, start_func, start_unit}, {1'b1, 6'h01, 2'd2});
    chk("R10", "pending cleared at accept", drv_irq, 4'b0000);
    cycle("R7 one cycle");
    chk("R7", "start single cycle", start, 1'b0);
    unit_sel_en = 1; unit_sel = 1; cycle("R9 select busy");
    cmd(8'h02, "R6 not idle");
    chk("R6", "no start when not idle", start, 1'b0);
    drv_irq_set = 4'b1000; cycle("R10 held");
    chk("R10", "held while busy", drv_irq, 4'b0000);
    xfer_done = 1; xfer_flags = 8'hFF; cycle("R11 done");
    chk("R11", "status after done", status, 8'hF7);
    chk("R8", "examine set", status[2], 1'b1);
    chk("R11", "irq released", drv_irq, 4'b1011);
    chk("R11", "ctl irq raised", ctl_irq, 1'b1);
    cmd(8'h01, "R9 check unit");
    chk("R9", "unit unchanged by busy select", start_unit, 2'd2);
    xfer_done = 1; cycle("R11 done2");
    cmd(8'h08, "R5 clear");
    chk("R5", "status after clear", status, 8'h0A);
    chk("R5", "pending after clear", drv_irq, 4'b0000);
    chk("R5", "arm gone, ctl irq low", ctl_irq, 1'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      unit_busy = $urandom;
      if (($urandom % 4) == 0) drv_irq_set = $urandom;
      if (($urandom % 4) == 0) drv_irq_clr = $urandom;
      if (($urandom % 8) == 0) ctl_irq_ack = 1;
      if (($urandom % 5) == 0) begin unit_sel_en = 1; unit_sel = $urandom; end
      if (r < 25) begin wr_byte_en = 1; wr_data = $urandom; end
      else if (r < 40) begin wr_half_en = 1; wr_data = $urandom; end
      else if (r < 58) begin
        cmd_en = 1;
        case ($urandom % 5)
          0: cmd_data = {2'($urandom), 6'h12};
          1: cmd_data = {2'($urandom), 6'h00};
          default: cmd_data = {2'($urandom), 6'($urandom) & 6'h37};
        endcase
        if (($urandom % 30) == 0) cmd_data[3] = 1;
        if (($urandom % 3) == 0) wr_byte_en = 1;
      end else if (r < 70) begin xfer_done = 1; xfer_flags = $urandom; end
      if (($urandom % 500) == 0) rst = 1;
      cycle("random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule